// File: doc/BRIEF.md
# Asynchronous Serial Frame Parity and Stop-Bit Codec

This block converts between data bytes and asynchronous serial character frames, and leaves bit timing and the register bus to its neighbours. On the send side a data byte becomes a frame vector, sent least significant bit first. The vector holds the data bits, then an optional parity bit, then one or two stop bits. On the receive side a captured frame vector is split back into its data. Parity and stop-bit violations are reported as separate flags. Both directions share one 6-bit line-format setting that selects the word length, the stop-bit count and the parity mode. Parity can be even, odd or stuck at one.

The block also watches a line-break level supplied by the receiver front end. A character-time tick paces it. When the break has lasted more than a programmed number of character times, the block delivers a single all-zero character with break, framing-error and error flags set. It delivers nothing more until the line has left the break state.

Frame vectors are 11 bits wide. Bit 0 is the first data bit. Positions past the last stop bit read as 1, the idle level.

Top module: `uart_frame_codec`

## Requirements
- R1: The word length is 5 plus `cfg[1:0]`. Data bit k sits at frame position k. Only the low word-length bits of `tx_data` are used. `rx_data` carries the received data bits with all bits above the word length at 0.
- R2: When `cfg[3]` (parity enable) is 1, a parity bit is placed at the position equal to the word length. With `cfg[4]`=1 (even) it equals the XOR of the used data bits; with `cfg[4]`=0 (odd) it is that XOR inverted.
- R3: When `cfg[3]`=1 and `cfg[5]`=1 (stick), the sent parity bit is 1 whatever the data and `cfg[4]`.
- R4: One stop bit of value 1 follows the data or parity bit, and a second one follows when `cfg[2]`=1. `tx_nbits` = word length + `cfg[3]` + 1 + `cfg[2]`. Every frame position at or above `tx_nbits` is 1.
- R5: `tx_frame_valid` is 1 exactly in the cycle after `tx_valid` is sampled high. `tx_frame` and `tx_nbits` are 0 in cycles when `tx_frame_valid` is 0.
- R6: On receive, `rx_par_err` is 0 without parity. With stick parity it is 1 when the parity bit is 0. Otherwise let x be the XOR of the data bits and the parity bit. The flag is x for even parity and the inverse of x for odd parity.
- R7: `rx_frm_err` is 1 when the first stop bit is 0, or when `cfg[2]`=1 and the second stop bit is 0.
- R8: A frame sampled with `rx_valid`=1 and `line_brk`=0 gives `rx_out_valid`=1 for exactly the next cycle, with `rx_err` = `rx_par_err` OR `rx_frm_err`. A frame offered while `line_brk`=1 is dropped. All receive outputs are 0 when `rx_out_valid` is 0.
- R9: While `line_brk`=1, each `char_tick` is counted. The tick that takes the count above `brk_limit` causes one output cycle in the next cycle. In that cycle `rx_data`=0, `rx_brk`=1, `rx_frm_err`=1 and `rx_err`=1, and `rx_par_err`=`cfg[3]`. A break event takes priority over a frame in the same cycle.
- R10: After a break event no further break is reported until `line_brk` has been sampled 0. The count then restarts from zero.
- R11: While `rst_n` is 0, all outputs are 0 at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg | input | 6 | Line format: [1:0] length-5, [2] two stops, [3] parity on, [4] even, [5] stick |
| tx_valid | input | 1 | Encode `tx_data` this cycle |
| tx_data | input | 8 | Byte to encode |
| tx_frame_valid | output | 1 | Encoded frame valid |
| tx_frame | output | 11 | Encoded frame, bit 0 sent first |
| tx_nbits | output | 4 | Meaningful bits in `tx_frame` |
| rx_valid | input | 1 | `rx_frame` holds a captured frame |
| rx_frame | input | 11 | Captured frame, bit 0 received first |
| line_brk | input | 1 | Receive line currently in break |
| char_tick | input | 1 | One pulse per character time |
| brk_limit | input | 8 | Character times that must be exceeded to report a break |
| rx_out_valid | output | 1 | Receive result valid |
| rx_data | output | 8 | Decoded data, zero above word length |
| rx_par_err | output | 1 | Parity error |
| rx_frm_err | output | 1 | Framing (stop-bit) error |
| rx_brk | output | 1 | Break character |
| rx_err | output | 1 | Any receive error |

## Verification
One cycle can hold a break event and an arriving frame together. The break must win and the frame must vanish. The bench provokes this by holding a break with a small limit while offering frames on every cycle, including the tick that crosses the limit. A second collision is a send request and a receive frame in the same cycle as the break line is released. Both results are expected one cycle later under the same format setting. A behavioural model built from queues and integers predicts every output on every clock, and directed checks pin the exact frame values for the stick, even and two-stop cases.

// File: rtl/uart_codec_pkg.sv
// Package: shared widths, line-format bit positions and format decode for
// the frame codec. Assumes an 8-bit data path (word lengths 5 to 8).
package uart_codec_pkg;
    localparam int DATA_W   = 8;
    localparam int MIN_LEN  = 5;
    localparam int FRAME_W  = DATA_W + 3;
    localparam int NB_W     = $clog2(FRAME_W + 1);
    localparam int CFG_W    = 6;
    localparam int CFG_STOP = 2;
    localparam int CFG_PEN  = 3;
    localparam int CFG_EVEN = 4;
    localparam int CFG_STK  = 5;

    typedef struct packed {
        logic [NB_W-1:0] len;
        logic            two_stop;
        logic            par_en;
        logic            par_even;
        logic            par_stick;
    } line_fmt_t;

    // Decode the 6-bit line-format setting into named fields.
    function automatic line_fmt_t decode_fmt(input logic [CFG_W-1:0] c);
        line_fmt_t f;
        f.len       = NB_W'(MIN_LEN) + {{(NB_W-2){1'b0}}, c[1:0]};
        f.two_stop  = c[CFG_STOP];
        f.par_en    = c[CFG_PEN];
        f.par_even  = c[CFG_EVEN];
        f.par_stick = c[CFG_STK];
        return f;
    endfunction

    // Mask keeping the low len bits of a data word.
    function automatic logic [DATA_W-1:0] len_mask(input logic [NB_W-1:0] len);
        logic [DATA_W-1:0] m;
        for (int i = 0; i < DATA_W; i++) m[i] = (i < int'(len));
        return m;
    endfunction
endpackage

// File: rtl/uart_tx_framer.sv
// Transmit framer: registers a frame vector built from a data byte.
// Assumes cfg is stable in the cycle tx_valid is high; output valid 1 cycle later.
module uart_tx_framer
    import uart_codec_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [CFG_W-1:0]    cfg,
    input  logic                tx_valid,
    input  logic [DATA_W-1:0]   tx_data,
    output logic                frame_valid,
    output logic [FRAME_W-1:0]  frame,
    output logic [NB_W-1:0]     nbits
);
    line_fmt_t          fmt;
    logic [DATA_W-1:0]  dmask;
    logic               pbit;
    logic [FRAME_W-1:0] frame_d;
    logic [NB_W-1:0]    nbits_d;

    // Build the frame: data LSB first, optional parity, stop/idle ones.
    always_comb begin
        fmt     = decode_fmt(cfg);
        dmask   = tx_data & len_mask(fmt.len);
        pbit    = fmt.par_stick ? 1'b1 : (fmt.par_even ? ^dmask : ~^dmask);
        frame_d = '1;
        for (int i = 0; i < DATA_W; i++)
            if (i < int'(fmt.len)) frame_d[i] = dmask[i];
        for (int i = 0; i < FRAME_W; i++)
            if (fmt.par_en && i == int'(fmt.len)) frame_d[i] = pbit;
        nbits_d = fmt.len + NB_W'(fmt.par_en) + NB_W'(1) + NB_W'(fmt.two_stop);
    end

    // Register the frame for one cycle; cleared when no request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_valid <= 1'b0;
            frame       <= '0;
            nbits       <= '0;
        end else begin
            frame_valid <= tx_valid;
            frame       <= tx_valid ? frame_d : '0;
            nbits       <= tx_valid ? nbits_d : '0;
        end
    end
endmodule

// File: rtl/uart_rx_deframer.sv
// Receive deframer (combinational): extracts data and checks parity and
// stop bits of a frame vector laid out per the current line format.
module uart_rx_deframer
    import uart_codec_pkg::*;
(
    input  logic [CFG_W-1:0]    cfg,
    input  logic [FRAME_W-1:0]  frame,
    output logic [DATA_W-1:0]   data,
    output logic                par_err,
    output logic                frm_err
);
    line_fmt_t fmt;
    logic      pbit;
    logic      stop0;
    logic      stop1;
    logic      x;

    // Locate the parity and stop positions, then judge them.
    always_comb begin
        fmt   = decode_fmt(cfg);
        data  = frame[DATA_W-1:0] & len_mask(fmt.len);
        pbit  = 1'b0;
        stop0 = 1'b1;
        stop1 = 1'b1;
        for (int i = 0; i < FRAME_W; i++) begin
            if (i == int'(fmt.len))                                pbit  = frame[i];
            if (i == int'(fmt.len) + int'(fmt.par_en))             stop0 = frame[i];
            if (i == int'(fmt.len) + int'(fmt.par_en) + 1)         stop1 = frame[i];
        end
        x = (^data) ^ pbit;
        if (!fmt.par_en)        par_err = 1'b0;
        else if (fmt.par_stick) par_err = ~pbit;
        else                    par_err = fmt.par_even ? x : ~x;
        frm_err = ~stop0 | (fmt.two_stop & ~stop1);
    end
endmodule

// File: rtl/uart_break_det.sv
// Break detector: counts character ticks while the line is in break and
// fires once when the count passes the limit; re-arms when break ends.
module uart_break_det #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_brk,
    input  logic             char_tick,
    input  logic [CNT_W-1:0] limit,
    output logic             fire
);
    logic [CNT_W-1:0] cnt;
    logic             armed;

    // Fire on the tick that would take the count above the limit.
    always_comb fire = line_brk && armed && char_tick && (cnt == limit);

    // Track the tick count and the armed state.
    always_ff @(posedge clk) begin
        if (!rst_n || !line_brk) begin
            cnt   <= '0;
            armed <= 1'b1;
        end else if (fire) begin
            cnt   <= '0;
            armed <= 1'b0;
        end else if (armed && char_tick) begin
            cnt   <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/uart_frame_codec.sv
// Top: frame codec. Send path in the framer; receive path is the deframer
// plus a result register in which a break event outranks a frame.
// Assumes frames and ticks are already aligned by a baud-timing neighbour.
module uart_frame_codec
    import uart_codec_pkg::*;
#(
    parameter int BRK_CW = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [CFG_W-1:0]    cfg,
    input  logic                tx_valid,
    input  logic [DATA_W-1:0]   tx_data,
    output logic                tx_frame_valid,
    output logic [FRAME_W-1:0]  tx_frame,
    output logic [NB_W-1:0]     tx_nbits,
    input  logic                rx_valid,
    input  logic [FRAME_W-1:0]  rx_frame,
    input  logic                line_brk,
    input  logic                char_tick,
    input  logic [BRK_CW-1:0]   brk_limit,
    output logic                rx_out_valid,
    output logic [DATA_W-1:0]   rx_data,
    output logic                rx_par_err,
    output logic                rx_frm_err,
    output logic                rx_brk,
    output logic                rx_err
);
    logic [DATA_W-1:0] dec_data;
    logic              dec_perr;
    logic              dec_ferr;
    logic              brk_fire;

    uart_tx_framer u_tx (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg         (cfg),
        .tx_valid    (tx_valid),
        .tx_data     (tx_data),
        .frame_valid (tx_frame_valid),
        .frame       (tx_frame),
        .nbits       (tx_nbits)
    );

    uart_rx_deframer u_rx (
        .cfg     (cfg),
        .frame   (rx_frame),
        .data    (dec_data),
        .par_err (dec_perr),
        .frm_err (dec_ferr)
    );

    uart_break_det #(.CNT_W(BRK_CW)) u_brk (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_brk  (line_brk),
        .char_tick (char_tick),
        .limit     (brk_limit),
        .fire      (brk_fire)
    );

    // Receive result register: break character first, then a clean-line frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_out_valid <= 1'b0;
            rx_data      <= '0;
            rx_par_err   <= 1'b0;
            rx_frm_err   <= 1'b0;
            rx_brk       <= 1'b0;
            rx_err       <= 1'b0;
        end else if (brk_fire) begin
            rx_out_valid <= 1'b1;
            rx_data      <= '0;
            rx_par_err   <= cfg[CFG_PEN];
            rx_frm_err   <= 1'b1;
            rx_brk       <= 1'b1;
            rx_err       <= 1'b1;
        end else if (rx_valid && !line_brk) begin
            rx_out_valid <= 1'b1;
            rx_data      <= dec_data;
            rx_par_err   <= dec_perr;
            rx_frm_err   <= dec_ferr;
            rx_brk       <= 1'b0;
            rx_err       <= dec_perr | dec_ferr;
        end else begin
            rx_out_valid <= 1'b0;
            rx_data      <= '0;
            rx_par_err   <= 1'b0;
            rx_frm_err   <= 1'b0;
            rx_brk       <= 1'b0;
            rx_err       <= 1'b0;
        end
    end
endmodule

// File: rtl/uart_frame_codec_chk.sv
// Checker: temporal properties of the codec ports, bound to the top.
module uart_frame_codec_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [1:0]  cfg_len,
    input logic        cfg_pen,
    input logic        tx_valid,
    input logic        tx_frame_valid,
    input logic [10:0] tx_frame,
    input logic [3:0]  tx_nbits,
    input logic        rx_valid,
    input logic        line_brk,
    input logic        rx_out_valid,
    input logic [7:0]  rx_data,
    input logic        rx_par_err,
    input logic        rx_frm_err,
    input logic        rx_brk,
    input logic        rx_err
);
    AST_TX_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |=> tx_frame_valid); // R5
    AST_TX_LAST_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        tx_frame_valid |-> tx_frame[tx_nbits - 4'd1]); // R4
    AST_RX_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !line_brk) |=> rx_out_valid); // R8
    AST_RX_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_out_valid |-> ($past(rx_valid) || rx_brk)); // R8
    AST_RX_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_out_valid && !rx_brk) |-> ((rx_data >> (4'd5 + {2'b00, $past(cfg_len)})) == 8'h00)); // R1
    AST_NO_PARITY_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_out_valid && !$past(cfg_pen)) |-> !rx_par_err || rx_brk); // R6
    AST_BRK_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        rx_brk |-> (rx_out_valid && rx_frm_err && rx_err && rx_data == 8'h00
                    && rx_par_err == $past(cfg_pen))); // R9
    AST_BRK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_brk |=> !rx_brk); // R10
endmodule

bind uart_frame_codec uart_frame_codec_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .cfg_len        (cfg[1:0]),
    .cfg_pen        (cfg[3]),
    .tx_valid       (tx_valid),
    .tx_frame_valid (tx_frame_valid),
    .tx_frame       (tx_frame),
    .tx_nbits       (tx_nbits),
    .rx_valid       (rx_valid),
    .line_brk       (line_brk),
    .rx_out_valid   (rx_out_valid),
    .rx_data        (rx_data),
    .rx_par_err     (rx_par_err),
    .rx_frm_err     (rx_frm_err),
    .rx_brk         (rx_brk),
    .rx_err         (rx_err)
);

// File: tb/uart_frame_codec_bench.sv
// Bench: behavioural per-cycle model compared on every clock, plus directed checks.
module uart_frame_codec_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  cfg = 6'h03;
    logic        tx_valid = 1'b0;
    logic [7:0]  tx_data = 8'h00;
    logic        tx_frame_valid;
    logic [10:0] tx_frame;
    logic [3:0]  tx_nbits;
    logic        rx_valid = 1'b0;
    logic [10:0] rx_frame = '1;
    logic        line_brk = 1'b0;
    logic        char_tick = 1'b0;
    logic [7:0]  brk_limit = 8'd2;
    logic        rx_out_valid;
    logic [7:0]  rx_data;
    logic        rx_par_err, rx_frm_err, rx_brk, rx_err;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int brk_seen = 0;
    bit cmp_en = 0;

    // model state and expected outputs
    bit        e_txv, e_rv, e_pe, e_fe, e_brk, e_err;
    bit [10:0] e_txf;
    bit [3:0]  e_txn;
    bit [7:0]  e_rd;
    int        m_cnt = 0;
    bit        m_armed = 1;

    always #2.5 clk = ~clk;

    uart_frame_codec u_uart_frame_codec (.*);

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h (t=%0t)", tag, act, exp, $time);
        end
    endtask

    function automatic void ref_tx(input bit [5:0] c, input bit [7:0] d,
                                   output bit [10:0] f, output bit [3:0] n);
        bit q[$];
        int len = 5 + c[1:0];
        bit x = 0;
        for (int i = 0; i < len; i++) begin q.push_back(d[i]); x ^= d[i]; end
        if (c[3]) q.push_back(c[5] ? 1'b1 : (c[4] ? x : !x));
        q.push_back(1'b1);
        if (c[2]) q.push_back(1'b1);
        f = '1;
        foreach (q[i]) f[i] = q[i];
        n = 4'(q.size());
    endfunction

    function automatic void ref_rx(input bit [5:0] c, input bit [10:0] f,
                                   output bit [7:0] d, output bit pe, output bit fe);
        int len = 5 + c[1:0];
        int pos;
        bit x = 0;
        bit pb;
        d = 0;
        for (int i = 0; i < len; i++) begin d[i] = f[i]; x ^= f[i]; end
        pos = len;
        pe = 0;
        if (c[3]) begin
            pb = f[pos];
            pos++;
            if (c[5]) pe = !pb;
            else      pe = c[4] ? (x ^ pb) : !(x ^ pb);
        end
        fe = !f[pos];
        if (c[2]) fe = fe | !f[pos + 1];
    endfunction

    // reference model, one step per clock
    always @(posedge clk) begin
        bit [10:0] f; bit [3:0] n; bit [7:0] d; bit pe, fe; bit fire;
        cyc++;
        if (!rst_n) begin
            {e_txv, e_rv, e_pe, e_fe, e_brk, e_err} = '0;
            e_txf = 0; e_txn = 0; e_rd = 0;
            m_cnt = 0; m_armed = 1;
        end else begin
            ref_tx(cfg, tx_data, f, n);
            e_txv = tx_valid;
            e_txf = tx_valid ? f : 11'h0;
            e_txn = tx_valid ? n : 4'h0;
            fire = 0;
            if (!line_brk) begin m_cnt = 0; m_armed = 1; end
            else if (m_armed && char_tick) begin
                if (m_cnt == int'(brk_limit)) begin fire = 1; m_armed = 0; m_cnt = 0; end
                else m_cnt++;
            end
            if (fire) begin
                e_rv = 1; e_rd = 0; e_pe = cfg[3]; e_fe = 1; e_brk = 1; e_err = 1;
            end else if (rx_valid && !line_brk) begin
                ref_rx(cfg, rx_frame, d, pe, fe);
                e_rv = 1; e_rd = d; e_pe = pe; e_fe = fe; e_brk = 0; e_err = pe | fe;
            end else begin
                {e_rv, e_pe, e_fe, e_brk, e_err} = '0; e_rd = 0;
            end
        end
    end

    // compare every cycle away from the active edge
    always @(negedge clk) begin
        if (rx_brk) brk_seen++;
        if (cmp_en) begin
            check("R5 tx_frame_valid", tx_frame_valid, e_txv);
            check("R1/R2 tx_frame", tx_frame, e_txf);
            check("R4 tx_nbits", tx_nbits, e_txn);
            check("R8 rx_out_valid", rx_out_valid, e_rv);
            check("R1 rx_data", rx_data, e_rd);
            check("R6 rx_par_err", rx_par_err, e_pe);
            check("R7 rx_frm_err", rx_frm_err, e_fe);
            check("R9 rx_brk", rx_brk, e_brk);
            check("R8 rx_err", rx_err, e_err);
        end
    end

    // watchdog
    always @(posedge clk) begin
        if (cyc > 100000) begin
            failures++;
            $display("FAIL R8 watchdog actual=%0d expected<=%0d", cyc, 100000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic step();
        @(negedge clk);
    endtask

    task automatic send_tx(input bit [5:0] c, input bit [7:0] d, input bit [10:0] ef,
                           input bit [3:0] en, input string tag);
        cfg = c; tx_valid = 1; tx_data = d;
        step();
        tx_valid = 0;
        check(tag, tx_frame, ef);
        check("R4 nbits directed", tx_nbits, en);
    endtask

    initial begin
        bit [10:0] f; bit [3:0] n; int b0;
        repeat (3) step();
        // R11: reset state
        check("R11 reset tx_frame_valid", tx_frame_valid, 0);
        check("R11 reset tx_frame", tx_frame, 0);
        check("R11 reset rx_out_valid", rx_out_valid, 0);
        check("R11 reset rx_err", rx_err, 0);
        rst_n = 1;
        step();
        cmp_en = 1;

        // directed frames
        send_tx(6'h03, 8'hA5, 11'h7A5, 4'd9,  "R1 8N1 frame");
        send_tx(6'h1E, 8'h41, 11'h741, 4'd10, "R2 7E2 frame");
        send_tx(6'h2B, 8'h01, 11'h701, 4'd10, "R3 stick frame");
        send_tx(6'h0B, 8'h01, 11'h601, 4'd10, "R2 odd frame");
        send_tx(6'h00, 8'hFF, 11'h7FF, 4'd6,  "R1 5N1 masks upper bits");

        // R6/R7 directed receive
        cfg = 6'h2B; rx_valid = 1; rx_frame = 11'h601; step();
        check("R6 stick parity zero flags", rx_par_err, 1);
        cfg = 6'h1E; rx_frame = 11'h541; step();
        check("R7 second stop zero", rx_frm_err, 1);
        check("R8 rx_err or", rx_err, 1);
        cfg = 6'h1B; rx_frame = 11'h601; step();
        check("R6 even parity mismatch", rx_par_err, 1);
        rx_valid = 0;

        // collision: tx + rx + break release in same cycle
        cfg = 6'h1B; line_brk = 1; rx_valid = 1; rx_frame = 11'h7FF; step();
        check("R8 frame dropped during break", rx_out_valid, 0);
        line_brk = 0; tx_valid = 1; tx_data = 8'h3C; rx_frame = 11'h63C; step();
        tx_valid = 0; rx_valid = 0;
        check("R8 frame after release", rx_data, 8'h3C);
        check("R5 tx alongside rx", tx_frame_valid, 1);

        // R9/R10 break with frames every cycle
        cfg = 6'h0B; brk_limit = 2; line_brk = 1; rx_valid = 1; rx_frame = 11'h601;
        b0 = brk_seen;
        for (int i = 0; i < 12; i++) begin char_tick = 1; step(); end
        char_tick = 0; rx_valid = 0; step();
        check("R9 single break char", brk_seen - b0, 1);
        line_brk = 0; step();
        line_brk = 1;
        for (int i = 0; i < 3; i++) begin char_tick = 1; step(); end
        char_tick = 0; step();
        check("R10 rearm after release", brk_seen - b0, 2);
        line_brk = 0; step();

        // random traffic checked by the model
        for (int i = 0; i < 4000; i++) begin
            cfg = 6'($urandom);
            tx_valid = $urandom_range(0, 1);
            tx_data = 8'($urandom);
            rx_valid = $urandom_range(0, 1);
            ref_tx(cfg, 8'($urandom), f, n);
            if ($urandom_range(0, 3) == 0) f[$urandom_range(0, 10)] ^= 1'b1;
            rx_frame = f;
            line_brk = (i % 200) > 160;
            char_tick = ($urandom_range(0, 2) == 0);
            brk_limit = 8'($urandom_range(0, 4));
            step();
        end
        tx_valid = 0; rx_valid = 0; line_brk = 0; char_tick = 0;
        repeat (3) step();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule